// File: doc/BRIEF.md
# Conversion Result Spool with Chip-Select Framed Serial Readout

This block sits between a conversion engine and a serial output pin. The engine hands it one 10-bit result with two extra sub-LSB bits per conversion. The block keeps these in a circular queue of sixteen entries. A separate single-entry slot holds the latest temperature measurement. A host reads results through a chip-select framed serial link. Each falling edge of the active-low select takes exactly one stored result and forms it into a 16-bit word: four zero bits, then the result, then the sub-LSB bits. The word is then shifted out, most significant bit first, one bit per falling edge of the serial clock.

The queue never refuses a write. When it is already full, the oldest unread result is dropped so the newest one can be kept. If there is no result when a frame opens, the data pin stays low for that whole frame. The serial clock and the select are sampled in the system clock domain, and both must be slower than it. The serial clock idles low, so the host can capture each bit on the rising serial clock edge. The conversion controller watches the full flag, the empty flag and the occupancy count.

Top module: `conv_result_spool`

## Requirements
- R1: The queue stores up to 16 results; after 16 writes into an empty queue `full` is 1 and `count` is 16.
- R2: A write into a full queue with no read in the same cycle discards the oldest stored result, keeps the new one, and leaves `count` at 16.
- R3: Each delivered word is `{4'b0000, result[9:0], sub[1:0]}`, so bits 15..12 are zero, bits 11..2 carry the result and bits 1..0 the sub-LSB bits.
- R4: Each falling edge of `cs_n` removes exactly one result from storage. This holds even when the frame ends before all 16 bits have been clocked out, so the next frame carries the next result.
- R5: The word goes out MSB first. Bit 15 is on `sdo` from the clock cycle after `cs_n` is sampled low, and each sampled falling edge of `sclk` moves to the next lower bit.
- R6: If neither the queue nor the temperature slot holds a result when `cs_n` falls, `sdo` stays 0 for the whole frame; `sdo` is also 0 whenever `cs_n` is high.
- R7: A valid temperature result is delivered ahead of all queued results, and the slot is emptied by that read. A newer temperature write replaces an unread one.
- R8: A queue write and a queue read in the same cycle both take effect and `count` does not change. When the queue is full, the read returns the oldest entry, which the write would otherwise have dropped.
- R9: A synchronous active-low reset empties the queue (`count` 0, `empty` 1, `full` 0) and the temperature slot.
- R10: `empty` is 1 exactly when `count` is 0, and `count` rises by one on each write into a non-full queue that has no read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Store one conversion result this cycle |
| wr_res | input | 10 | Conversion result |
| wr_sub | input | 2 | Sub-LSB bits of the conversion result |
| temp_wr_en | input | 1 | Store a temperature result this cycle |
| temp_res | input | 10 | Temperature result |
| temp_sub | input | 2 | Sub-LSB bits of the temperature result |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idles low |
| sdo | output | 1 | Serial data to the host |
| full | output | 1 | Queue holds 16 results |
| empty | output | 1 | Queue holds no result |
| count | output | 5 | Number of results in the queue |

## Verification
A conversion write and a frame-opening read can land in the same system clock edge. The bench provokes this by raising `wr_en` in the same cycle that `cs_n` is driven low. It does this once with a partly filled queue and once with a full one. It judges the outcome by `count` staying unchanged and by the full-queue frame returning the oldest entry rather than the new one. It also drains everything that follows, to confirm that the new result was kept behind the others in order.

// File: rtl/rspool_pkg.sv
`timescale 1ns/1ps
// Shared widths, the stored sample type and the word formatter for the
// result spool. Assumes the padded word is at least as wide as the sample.
package rspool_pkg;
    localparam int RES_W  = 10;
    localparam int SUB_W  = 2;
    localparam int WORD_W = 16;
    localparam int PAD_W  = WORD_W - RES_W - SUB_W;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [SUB_W-1:0] sub;
    } sample_t;

    // Places leading zero padding above the result and sub-LSB bits.
    function automatic logic [WORD_W-1:0] pack_word(sample_t s);
        return {{PAD_W{1'b0}}, s.res, s.sub};
    endfunction
endpackage

// File: rtl/rspool_queue.sv
`timescale 1ns/1ps
// Circular result queue that overwrites its oldest entry when full.
// Assumes pop is only meaningful when the queue is not empty; an empty pop
// is ignored. Storage cells carry no reset; only the pointers and the count do.
module rspool_queue
    import rspool_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  sample_t       push_data,
    input  logic          pop,
    output sample_t       head,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    sample_t         store [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic            pop_ok;
    logic            drop_old;

    // Advances a pointer with wrap at the last slot.
    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
    endfunction

    // Derives the honoured pop and the overwrite case.
    always_comb begin
        full     = (count == CW'(DEPTH));
        empty    = (count == '0);
        pop_ok   = pop && !empty;
        drop_old = push && full && !pop_ok;
        head     = store[rd_ptr];
    end

    // Writes the incoming sample into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Moves pointers and occupancy for push, pop, both, or overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (pop_ok || drop_old) begin
                rd_ptr <= step(rd_ptr);
            end
            if (push && !pop_ok && !full) begin
                count <= count + 1'b1;
            end else if (pop_ok && !push) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rspool_temp_slot.sv
`timescale 1ns/1ps
// Single-entry holding slot for the temperature result. A write always
// replaces the content; a take clears the valid flag unless a write lands
// in the same cycle, in which case the new value stays valid.
module rspool_temp_slot
    import rspool_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  sample_t wr_data,
    input  logic    take,
    output logic    valid,
    output sample_t data
);
    // Captures the newest temperature sample.
    always_ff @(posedge clk) begin
        if (wr) begin
            data <= wr_data;
        end
    end

    // Tracks whether an unread temperature sample is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (wr) begin
            valid <= 1'b1;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rspool_shifter.sv
`timescale 1ns/1ps
// Per-frame output shift register. Loads one word at frame start, moves one
// bit per shift request, MSB first, and stops after a full word. Idle
// clears it so the output rests low between frames.
module rspool_shifter
    import rspool_pkg::*;
#(
    localparam int NW = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              sdo
);
    logic [WORD_W-1:0] shreg;
    logic [NW-1:0]     shifted;

    // Loads, shifts or clears the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            shifted <= '0;
        end else if (idle) begin
            shreg   <= '0;
            shifted <= '0;
        end else if (load) begin
            shreg   <= load_word;
            shifted <= '0;
        end else if (shift && (shifted < NW'(WORD_W))) begin
            shreg   <= {shreg[WORD_W-2:0], 1'b0};
            shifted <= shifted + 1'b1;
        end
    end

    // Presents the current top bit on the serial line.
    always_comb begin
        sdo = shreg[WORD_W-1];
    end
endmodule

// File: rtl/conv_result_spool.sv
`timescale 1ns/1ps
// Result spool top. Buffers conversion results and one temperature result
// and releases one padded word per chip-select frame. Assumes cs_n and sclk
// are slower than clk; both are sampled once per clk, and sclk idles low.
module conv_result_spool
    import rspool_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RES_W-1:0] wr_res,
    input  logic [SUB_W-1:0] wr_sub,
    input  logic             temp_wr_en,
    input  logic [RES_W-1:0] temp_res,
    input  logic [SUB_W-1:0] temp_sub,
    input  logic             cs_n,
    input  logic             sclk,
    output logic             sdo,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);
    logic              cs_q;
    logic              sclk_q;
    logic              frame_start;
    logic              sclk_fall;
    logic              temp_valid;
    logic              take_temp;
    logic              take_queue;
    sample_t           head;
    sample_t           temp_data;
    sample_t           adc_in;
    sample_t           temp_in;
    logic [WORD_W-1:0] out_word;

    // Keeps the previous samples of the host strobes for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    // Detects frame start and shift edges and chooses the source of the word.
    always_comb begin
        frame_start = cs_q && !cs_n;
        sclk_fall   = sclk_q && !sclk && !cs_n && !frame_start;
        take_temp   = frame_start && temp_valid;
        take_queue  = frame_start && !temp_valid;
        adc_in      = '{res: wr_res, sub: wr_sub};
        temp_in     = '{res: temp_res, sub: temp_sub};
        if (temp_valid) begin
            out_word = pack_word(temp_data);
        end else if (!empty) begin
            out_word = pack_word(head);
        end else begin
            out_word = '0;
        end
    end

    rspool_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (adc_in),
        .pop       (take_queue),
        .head      (head),
        .full      (full),
        .empty     (empty),
        .count     (count)
    );

    rspool_temp_slot u_temp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (temp_wr_en),
        .wr_data (temp_in),
        .take    (take_temp),
        .valid   (temp_valid),
        .data    (temp_data)
    );

    rspool_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (cs_n),
        .load      (frame_start),
        .load_word (out_word),
        .shift     (sclk_fall),
        .sdo       (sdo)
    );
endmodule

// File: rtl/rspool_checker.sv
`timescale 1ns/1ps
// Property checker for the result spool, attached to the top by bind.
module rspool_checker #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          temp_wr_en,
    input logic          cs_n,
    input logic          sdo,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] count,
    input logic          frame_start,
    input logic          temp_valid
);
    // R1: occupancy never exceeds the queue depth.
    p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2: writing into a full queue leaves it full.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> full);

    // R6: an empty frame puts a low level on the data line.
    p_empty_frame_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && empty && !temp_valid) |=> !sdo);

    // R6: the data line rests low while the frame is closed.
    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo);

    // R7: reading the temperature slot empties it.
    p_temp_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && temp_valid && !temp_wr_en) |=> !temp_valid);

    // R8: simultaneous write and queue read keep the count.
    p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && frame_start && !temp_valid && !empty) |=> (count == $past(count)));

    // R10: a plain write into a non-full queue adds one entry.
    p_push_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !(frame_start && !temp_valid && !empty))
        |=> (count == $past(count) + 1'b1));

    // R9: reset leaves the queue and temperature slot empty.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && empty && !temp_valid));
endmodule

bind conv_result_spool rspool_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .temp_wr_en  (temp_wr_en),
    .cs_n        (cs_n),
    .sdo         (sdo),
    .full        (full),
    .empty       (empty),
    .count       (count),
    .frame_start (frame_start),
    .temp_valid  (temp_valid)
);

// File: tb/tb_conv_result_spool.sv
`timescale 1ns/1ps
// Directed bench for the result spool: one task per scenario.
module tb_conv_result_spool;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_res = '0;
    logic [1:0] wr_sub = '0;
    logic       temp_wr_en = 1'b0;
    logic [9:0] temp_res = '0;
    logic [1:0] temp_sub = '0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdo;
    logic       full;
    logic       empty;
    logic [4:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    conv_result_spool dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_res(wr_res), .wr_sub(wr_sub),
        .temp_wr_en(temp_wr_en), .temp_res(temp_res), .temp_sub(temp_sub),
        .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .full(full), .empty(empty), .count(count)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] word_of(logic [9:0] r, logic [1:0] s);
        return {4'b0000, r, s};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [9:0] r, input logic [1:0] s);
        wr_en = 1'b1; wr_res = r; wr_sub = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_temp(input logic [9:0] r, input logic [1:0] s);
        temp_wr_en = 1'b1; temp_res = r; temp_sub = s;
        @(negedge clk);
        temp_wr_en = 1'b0;
    endtask

    // Opens a frame, optionally writes a result in the opening cycle,
    // and collects nbits bits, MSB first; unread low bits stay zero.
    task automatic frame(input int nbits, input bit with_push,
                         input logic [9:0] r, output logic [15:0] w);
        w = '0;
        if (with_push) begin
            wr_en = 1'b1; wr_res = r; wr_sub = 2'b00;
        end
        cs_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        w[15] = sdo;
        for (int i = 1; i < nbits; i++) begin
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
            w[15-i] = sdo;
        end
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] w;
        do_reset();
        chk("R9 count after reset", count, 0);
        chk("R9 empty after reset", empty, 1);
        chk("R9 full after reset", full, 0);
        chk("R6 sdo idle after reset", sdo, 0);
        push(10'h011, 2'b01);
        push(10'h022, 2'b10);
        push_temp(10'h033, 2'b11);
        do_reset();
        chk("R9 count cleared mid-run", count, 0);
        frame(16, 1'b0, '0, w);
        chk("R9 temperature slot cleared", w, 0);
    endtask

    task automatic t_empty();
        logic [15:0] w;
        frame(16, 1'b0, '0, w);
        chk("R6 empty frame data", w, 0);
        chk("R6 sdo low after frame", sdo, 0);
        chk("R10 empty with no data", empty, 1);
    endtask

    task automatic t_basic();
        logic [15:0] w;
        push(10'h2A5, 2'b01);
        push(10'h3FF, 2'b11);
        push(10'h001, 2'b10);
        chk("R10 count after three writes", count, 3);
        chk("R10 not empty", empty, 0);
        frame(16, 1'b0, '0, w);
        chk("R3 R5 first word MSB first", w, word_of(10'h2A5, 2'b01));
        frame(16, 1'b0, '0, w);
        chk("R3 full-scale word padding", w, word_of(10'h3FF, 2'b11));
        frame(16, 1'b0, '0, w);
        chk("R3 small word", w, word_of(10'h001, 2'b10));
        chk("R4 count after three reads", count, 0);
    endtask

    task automatic t_full();
        logic [15:0] w;
        for (int i = 0; i < 16; i++) push(10'(i + 16), 2'b01);
        chk("R1 full after sixteen writes", full, 1);
        chk("R1 count sixteen", count, 16);
        push(10'd32, 2'b01);
        push(10'd33, 2'b01);
        chk("R2 count holds at sixteen", count, 16);
        for (int i = 0; i < 16; i++) begin
            frame(16, 1'b0, '0, w);
            chk("R2 oldest dropped, order kept", w, word_of(10'(i + 18), 2'b01));
        end
        chk("R10 empty after drain", empty, 1);
    endtask

    task automatic t_temp();
        logic [15:0] w;
        push(10'h155, 2'b00);
        push_temp(10'h0F0, 2'b01);
        push_temp(10'h10F, 2'b10);
        frame(16, 1'b0, '0, w);
        chk("R7 newest temperature first", w, word_of(10'h10F, 2'b10));
        chk("R7 queue untouched by temp read", count, 1);
        frame(16, 1'b0, '0, w);
        chk("R7 queue after temperature", w, word_of(10'h155, 2'b00));
        frame(16, 1'b0, '0, w);
        chk("R7 temperature slot emptied", w, 0);
    endtask

    task automatic t_early();
        logic [15:0] w;
        push(10'h2C3, 2'b11);
        push(10'h0A7, 2'b01);
        frame(3, 1'b0, '0, w);
        chk("R5 top three bits of short frame", w[15:13], 3'b000);
        chk("R4 short frame consumed word", count, 1);
        frame(16, 1'b0, '0, w);
        chk("R4 next frame gets next word", w, word_of(10'h0A7, 2'b01));
    endtask

    task automatic t_same_cycle();
        logic [15:0] w;
        push(10'h101, 2'b00);
        push(10'h102, 2'b00);
        frame(16, 1'b1, 10'h1AA, w);
        chk("R8 partial queue read word", w, word_of(10'h101, 2'b00));
        chk("R8 count unchanged", count, 2);
        frame(16, 1'b0, '0, w);
        frame(16, 1'b0, '0, w);
        chk("R8 written word kept", w, word_of(10'h1AA, 2'b00));
        for (int i = 0; i < 16; i++) push(10'(i + 64), 2'b00);
        frame(16, 1'b1, 10'h3C0, w);
        chk("R8 full queue read takes oldest", w, word_of(10'd64, 2'b00));
        chk("R8 full count unchanged", count, 16);
        for (int i = 1; i < 16; i++) frame(16, 1'b0, '0, w);
        chk("R8 second last word", w, word_of(10'd79, 2'b00));
        frame(16, 1'b0, '0, w);
        chk("R8 new word last", w, word_of(10'h3C0, 2'b00));
    endtask

    initial begin
        t_reset();
        t_empty();
        t_basic();
        t_full();
        t_temp();
        t_early();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual still running, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule